// File: doc/BRIEF.md
# Immediate-Extension and Source-Substitution Prefix Unit

This unit sits in the decode stage of a small processor. It handles two kinds of prefix instruction. The first is an augment prefix. It captures the upper 23 bits of a future 32-bit immediate and holds them as a pending value. That value waits until an instruction with an immediate source operand takes it, however many other instructions run in between. Instructions that read their source from a register leave the value alone. Source-substitution prefixes leave it alone as well. While the value is pending, interrupt entry is held off.

The second is a source-substitution prefix. Its source operand is split into two parts. The low 9 bits are a base offset: they are added to the destination register value, and the low 9 bits of that sum replace the source field of the next valid instruction. Bits 17:9 are a signed step: it is added to the destination register, and the sum is presented for write-back.

A mode pin picks one of two behaviours for a substitution prefix with an immediate source while augment bits are pending. In legacy mode the prefix reads the augment bits without clearing them, so the same bits reach the next immediate consumer as well. In corrected mode the prefix ignores the pending bits.

Top module: `imm_ext_unit`

## Requirements
- R1: A valid instruction of class 2'b01 (augment prefix) loads `in_aug_bits` into the holding register and sets `aug_pending`. When an augment prefix arrives while a value is already pending, its bits replace the held bits and `aug_pending` stays 1.
- R2: A valid instruction of class 2'b00 or 2'b11 (plain) with `in_imm`=1 behaves as follows. If `aug_pending` is set, `s_value` is {held bits, 9-bit field} and `aug_pending` is 0 on the next cycle. If it is clear, `s_value` is the 9-bit field zero-extended.
- R3: A plain instruction with `in_imm`=0 (register source) gets the 9-bit field zero-extended in `s_value`. It leaves `aug_pending` and the held bits unchanged.
- R4: A valid instruction of class 2'b10 (substitution prefix) never clears `aug_pending`.
- R5: In legacy mode (`legacy_mode`=1), a substitution prefix with `in_imm`=1 and a pending value uses {held bits, field} as its source. It steps the pointer by the augmented step, and the same held bits still extend the next immediate consumer.
- R6: In corrected mode (`legacy_mode`=0), a substitution prefix with `in_imm`=1 uses the zero-extended 9-bit field. Its step is therefore zero and `ptr_wdata` equals `in_dval`.
- R7: A substitution prefix with `in_imm`=0 takes its source value from `in_sdata` and presents it on `s_value`.
- R8: For a valid substitution prefix, `ptr_we`=1 and `ptr_wdata` = `in_dval` + sign-extended source bits 17:9. The low 9 bits of (`in_dval` + source bits 8:0) replace the 9-bit field of the next valid instruction only. After any valid non-prefix instruction, `alt_pending` is 0.
- R9: `irq_ack` equals `irq_req` while `aug_pending` is 0, and is 0 while `aug_pending` is 1.
- R10: Reset (`rst_n`=0) clears `aug_pending` and `alt_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | 1 = substitution prefix reads pending augment bits; 0 = it ignores them |
| in_valid | input | 1 | Instruction descriptor valid |
| in_class | input | 2 | 00/11 plain, 01 augment prefix, 10 substitution prefix |
| in_imm | input | 1 | Source operand is an immediate |
| in_sfield | input | 9 | Source field from the instruction word |
| in_aug_bits | input | 23 | Upper immediate bits carried by an augment prefix |
| in_dval | input | 32 | Destination register value |
| in_sdata | input | 32 | Value read from the source register |
| irq_req | input | 1 | Interrupt request |
| s_value | output | 32 | Effective source operand or address |
| ptr_we | output | 1 | Pointer write-back enable |
| ptr_wdata | output | 32 | Stepped destination value |
| aug_pending | output | 1 | Augment value pending |
| alt_pending | output | 1 | Source substitution armed for next instruction |
| irq_ack | output | 1 | Interrupt entry granted |

## Verification
The bench targets a register-source instruction placed between an augment prefix and its consumer. A design that consumed on any instruction would lose the bits, and the later immediate would come out unextended. Back-to-back augment prefixes catch a design that keeps the first bits or drops the pending flag. Both modes run the leaky example: augmented source 1024 on a substitution prefix, followed by an immediate zero. A design that mixes the modes shows the wrong step of 2 versus 0, or a consumer that misses 0x400. Interrupt requests raised while a value is pending catch a design that lets interrupt entry through too early, and instructions following a substitution catch a design that applies the substituted field for more than one instruction.

// File: rtl/imx_pkg.sv
package imx_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN = 2'b00,
    CLS_AUG   = 2'b01,
    CLS_ALT   = 2'b10,
    CLS_RSVD  = 2'b11
  } op_class_e;
endpackage

// File: rtl/imx_aug_hold.sv
module imx_aug_hold #(
  parameter int HI_W = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            consume,
  input  logic [HI_W-1:0] load_bits,
  output logic [HI_W-1:0] hold_bits,
  output logic            pending
);
  // a new prefix wins over consumption; both cannot occur on one instruction
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      hold_bits <= '0;
    end else if (load) begin
      pending   <= 1'b1;
      hold_bits <= load_bits;
    end else if (consume) begin
      pending   <= 1'b0;
    end
  end
endmodule

// File: rtl/imx_sel.sv
module imx_sel
  import imx_pkg::*;
#(
  parameter int IMM_W  = 9,
  parameter int WORD_W = 32,
  localparam int HI_W  = WORD_W - IMM_W
) (
  input  logic              valid,
  input  op_class_e         cls,
  input  logic              imm,
  input  logic              legacy,
  input  logic [IMM_W-1:0]  sfield,
  input  logic              alt_pending,
  input  logic [IMM_W-1:0]  alt_addr,
  input  logic              aug_pending,
  input  logic [HI_W-1:0]   hold_bits,
  input  logic [WORD_W-1:0] sdata,
  output logic [WORD_W-1:0] s_eff,
  output logic              aug_use,
  output logic              aug_consume
);
  function automatic logic [WORD_W-1:0] widen(input logic [HI_W-1:0] hi,
                                              input logic [IMM_W-1:0] lo,
                                              input logic use_hi);
    return use_hi ? {hi, lo} : {{HI_W{1'b0}}, lo};
  endfunction

  logic [IMM_W-1:0] field;
  logic             is_plain;

  always_comb begin
    field       = alt_pending ? alt_addr : sfield;
    is_plain    = (cls == CLS_PLAIN) || (cls == CLS_RSVD);
    aug_use     = imm && aug_pending && (is_plain || (cls == CLS_ALT && legacy));
    aug_consume = valid && imm && aug_pending && is_plain;
    if (cls == CLS_ALT && !imm) s_eff = sdata;
    else                        s_eff = widen(hold_bits, field, aug_use);
  end
endmodule

// File: rtl/imx_alt_unit.sv
module imx_alt_unit #(
  parameter int IMM_W  = 9,
  parameter int WORD_W = 32,
  localparam int SRC_W = 2 * IMM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              advance,
  input  logic [SRC_W-1:0]  src,
  input  logic [WORD_W-1:0] dval,
  output logic              alt_pending,
  output logic [IMM_W-1:0]  alt_addr,
  output logic [WORD_W-1:0] ptr_wdata
);
  function automatic logic [IMM_W-1:0] base_addr(input logic [WORD_W-1:0] d,
                                                 input logic [SRC_W-1:0] s);
    logic [WORD_W-1:0] sum;
    sum = d + {{(WORD_W-IMM_W){1'b0}}, s[IMM_W-1:0]};
    return sum[IMM_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] stepped(input logic [WORD_W-1:0] d,
                                                input logic [SRC_W-1:0] s);
    return d + {{(WORD_W-IMM_W){s[SRC_W-1]}}, s[SRC_W-1:IMM_W]};
  endfunction

  assign ptr_wdata = stepped(dval, src);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alt_pending <= 1'b0;
      alt_addr    <= '0;
    end else if (fire) begin
      alt_pending <= 1'b1;
      alt_addr    <= base_addr(dval, src);
    end else if (advance) begin
      alt_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/imm_ext_unit.sv
module imm_ext_unit
  import imx_pkg::*;
#(
  parameter int IMM_W  = 9,
  parameter int WORD_W = 32,
  localparam int HI_W  = WORD_W - IMM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_mode,
  input  logic              in_valid,
  input  logic [1:0]        in_class,
  input  logic              in_imm,
  input  logic [IMM_W-1:0]  in_sfield,
  input  logic [HI_W-1:0]   in_aug_bits,
  input  logic [WORD_W-1:0] in_dval,
  input  logic [WORD_W-1:0] in_sdata,
  input  logic              irq_req,
  output logic [WORD_W-1:0] s_value,
  output logic              ptr_we,
  output logic [WORD_W-1:0] ptr_wdata,
  output logic              aug_pending,
  output logic              alt_pending,
  output logic              irq_ack
);
  op_class_e        cls;
  logic [HI_W-1:0]  hold_bits;
  logic [IMM_W-1:0] alt_addr;
  logic             aug_use;
  logic             aug_consume;
  logic             aug_load;
  logic             alt_fire;
  logic             alt_advance;

  assign cls         = op_class_e'(in_class);
  assign aug_load    = in_valid && (cls == CLS_AUG);
  assign alt_fire    = in_valid && (cls == CLS_ALT);
  assign alt_advance = in_valid && (cls != CLS_ALT);
  assign ptr_we      = alt_fire;
  assign irq_ack     = irq_req && !aug_pending;

  imx_aug_hold #(.HI_W(HI_W)) u_aug (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (aug_load),
    .consume   (aug_consume),
    .load_bits (in_aug_bits),
    .hold_bits (hold_bits),
    .pending   (aug_pending)
  );

  imx_sel #(.IMM_W(IMM_W), .WORD_W(WORD_W)) u_sel (
    .valid       (in_valid),
    .cls         (cls),
    .imm         (in_imm),
    .legacy      (legacy_mode),
    .sfield      (in_sfield),
    .alt_pending (alt_pending),
    .alt_addr    (alt_addr),
    .aug_pending (aug_pending),
    .hold_bits   (hold_bits),
    .sdata       (in_sdata),
    .s_eff       (s_value),
    .aug_use     (aug_use),
    .aug_consume (aug_consume)
  );

  imx_alt_unit #(.IMM_W(IMM_W), .WORD_W(WORD_W)) u_alt (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (alt_fire),
    .advance     (alt_advance),
    .src         (s_value[2*IMM_W-1:0]),
    .dval        (in_dval),
    .alt_pending (alt_pending),
    .alt_addr    (alt_addr),
    .ptr_wdata   (ptr_wdata)
  );
endmodule

// File: rtl/imx_chk.sv
module imx_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              legacy_mode,
  input logic              in_valid,
  input logic [1:0]        in_class,
  input logic              in_imm,
  input logic [WORD_W-1:0] in_dval,
  input logic              irq_req,
  input logic [WORD_W-1:0] ptr_wdata,
  input logic              aug_pending,
  input logic              alt_pending,
  input logic              irq_ack,
  input logic              aug_consume
);
  // R1
  aug_load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'b01) |=> aug_pending);

  // R2
  consume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aug_consume |=> !aug_pending);

  // R3
  reg_src_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'b00 && !in_imm) |=> $stable(aug_pending));

  // R4
  alt_keeps_aug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'b10 && aug_pending) |=> aug_pending);

  // R6
  fixed_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy_mode && in_valid && in_class == 2'b10 && in_imm) |-> (ptr_wdata == in_dval));

  // R8
  alt_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'b10) |=> alt_pending);

  // R8
  alt_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class != 2'b10) |=> !alt_pending);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aug_pending |-> !irq_ack);

  // R9
  irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!aug_pending && irq_req) |-> irq_ack);
endmodule

bind imm_ext_unit imx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .legacy_mode (legacy_mode),
  .in_valid    (in_valid),
  .in_class    (in_class),
  .in_imm      (in_imm),
  .in_dval     (in_dval),
  .irq_req     (irq_req),
  .ptr_wdata   (ptr_wdata),
  .aug_pending (aug_pending),
  .alt_pending (alt_pending),
  .irq_ack     (irq_ack),
  .aug_consume (aug_consume)
);

// File: tb/imm_ext_unit_test.sv
module imm_ext_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        legacy_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_class = 2'b00;
  logic        in_imm = 1'b0;
  logic [8:0]  in_sfield = '0;
  logic [22:0] in_aug_bits = '0;
  logic [31:0] in_dval = '0;
  logic [31:0] in_sdata = '0;
  logic        irq_req = 1'b0;
  logic [31:0] s_value;
  logic        ptr_we;
  logic [31:0] ptr_wdata;
  logic        aug_pending;
  logic        alt_pending;
  logic        irq_ack;

  int checks = 0;
  int errors = 0;

  // bench-side model state
  logic        m_aug;
  logic [22:0] m_hold;
  logic        m_alt;
  logic [8:0]  m_addr;
  logic [31:0] last_s;
  logic [31:0] last_w;

  always #2 clk = ~clk;

  imm_ext_unit uut (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .in_valid(in_valid),
    .in_class(in_class), .in_imm(in_imm), .in_sfield(in_sfield),
    .in_aug_bits(in_aug_bits), .in_dval(in_dval), .in_sdata(in_sdata),
    .irq_req(irq_req), .s_value(s_value), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .aug_pending(aug_pending), .alt_pending(alt_pending), .irq_ack(irq_ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // source operand expected from the requirements
  function automatic logic [31:0] want_src(input logic [1:0] c, input logic im,
                                           input logic [8:0] f, input logic [31:0] sd);
    logic [8:0] fld;
    logic       ext;
    fld = m_alt ? m_addr : f;
    if (c == 2'b10 && !im) return sd;
    if (c == 2'b10) ext = im && m_aug && legacy_mode;
    else if (c == 2'b01) ext = 1'b0;
    else ext = im && m_aug;
    return ext ? {m_hold, fld} : {23'd0, fld};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    m_aug = 1'b0; m_alt = 1'b0; m_hold = '0; m_addr = '0;
    #1;
    check("R10 aug_pending after reset", {31'd0, aug_pending}, 32'd0);
    check("R10 alt_pending after reset", {31'd0, alt_pending}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic v, input logic [1:0] c, input logic im,
                      input logic [8:0] f, input logic [22:0] ab, input logic [31:0] d,
                      input logic [31:0] sd, input logic irq, input string tag);
    logic [31:0] es;
    logic [31:0] ew;
    @(negedge clk);
    in_valid = v; in_class = c; in_imm = im; in_sfield = f;
    in_aug_bits = ab; in_dval = d; in_sdata = sd; irq_req = irq;
    #1;
    es = want_src(c, im, f, sd);
    ew = d + {{23{es[17]}}, es[17:9]};
    last_s = s_value;
    last_w = ptr_wdata;
    check({tag, " R9 irq_ack"}, {31'd0, irq_ack}, {31'd0, irq && !m_aug});
    check({tag, " R1 aug_pending"}, {31'd0, aug_pending}, {31'd0, m_aug});
    check({tag, " R8 alt_pending"}, {31'd0, alt_pending}, {31'd0, m_alt});
    check({tag, " R8 ptr_we"}, {31'd0, ptr_we}, {31'd0, v && c == 2'b10});
    if (v) begin
      check({tag, " R2 s_value"}, s_value, es);
      if (c == 2'b10) check({tag, " R8 ptr_wdata"}, ptr_wdata, ew);
      // model update for the coming edge
      if (c == 2'b01) begin
        m_aug = 1'b1; m_hold = ab;
      end else if (c != 2'b10 && im && m_aug) begin
        m_aug = 1'b0;
      end
      if (c == 2'b10) begin
        m_alt = 1'b1;
        m_addr = d[8:0] + es[8:0];
      end else begin
        m_alt = 1'b0;
      end
    end
  endtask

  task automatic leaky_example(input logic leg);
    legacy_mode = leg;
    do_reset();
    step(1, 2'b01, 0, 9'd0, 23'd2, 32'd0, 32'd0, 0, "EX aug");
    step(1, 2'b10, 1, 9'd0, 23'd0, 32'h10, 32'd0, 0, "EX alt");
    if (leg) begin
      check("R5 legacy alt source", last_s, 32'h400);
      check("R5 legacy step by 2", last_w, 32'h12);
    end else begin
      check("R6 corrected alt source", last_s, 32'h0);
      check("R6 corrected no step", last_w, 32'h10);
    end
    check("R4 pending after alt", {31'd0, aug_pending}, 32'd1);
    step(1, 2'b00, 0, 9'h77, 23'd0, 32'd0, 32'd0, 1, "EX regsrc");
    check("R8 substituted field", last_s, 32'h10);
    check("R3 pending kept by register source", {31'd0, aug_pending}, 32'd1);
    step(1, 2'b00, 1, 9'd0, 23'd0, 32'd0, 32'd0, 1, "EX consume");
    check("R5 consumer gets held bits", last_s, 32'h400);
    step(1, 2'b00, 1, 9'd5, 23'd0, 32'd0, 32'd0, 1, "EX after");
    check("R2 no extension after consume", last_s, 32'd5);
    check("R9 irq_ack once cleared", {31'd0, irq_ack}, 32'd1);
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_aug = 0; m_alt = 0; m_hold = '0; m_addr = '0; last_s = '0; last_w = '0;

    leaky_example(1'b1);
    leaky_example(1'b0);

    // back-to-back augment prefixes
    do_reset();
    step(1, 2'b01, 0, 9'd0, 23'h1, 32'd0, 32'd0, 1, "R1 first aug");
    step(1, 2'b01, 0, 9'd0, 23'h5a5a5, 32'd0, 32'd0, 1, "R1 second aug");
    step(1, 2'b00, 1, 9'h1ff, 23'd0, 32'd0, 32'd0, 1, "R1 consume");
    check("R1 newest bits win", last_s, {23'h5a5a5, 9'h1ff});

    // register-source substitution prefix
    step(1, 2'b10, 0, 9'd0, 23'd0, 32'h100, 32'hfffffe03, 0, "R7 alt reg");
    check("R7 source from register", last_s, 32'hfffffe03);
    check("R7 negative step", last_w, 32'hff);
    step(0, 2'b00, 1, 9'd9, 23'd0, 32'd0, 32'd0, 0, "R8 idle");
    step(1, 2'b00, 1, 9'd9, 23'd0, 32'd0, 32'd0, 0, "R8 use");
    check("R8 address after idle", last_s, 32'h103);
    step(1, 2'b00, 1, 9'd9, 23'd0, 32'd0, 32'd0, 0, "R8 once");
    check("R8 one instruction only", last_s, 32'd9);

    // random traffic, both modes
    for (int mode = 0; mode < 2; mode++) begin
      legacy_mode = mode[0];
      do_reset();
      for (int n = 0; n < 3000; n++) begin
        logic [2:0] pick;
        logic [1:0] c;
        logic [22:0] ab;
        pick = 3'($urandom % 8);
        c = (pick < 3) ? 2'b00 : (pick == 3) ? 2'b11 : (pick < 6) ? 2'b01 : 2'b10;
        ab = ($urandom % 2 == 0) ? 23'($urandom % 1024) : 23'($urandom);
        step(($urandom % 8) != 0, c, 1'($urandom), 9'($urandom), ab,
             $urandom, $urandom, 1'($urandom), "RND");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule